// File: doc/BRIEF.md
# Thermal Trip Latch and Shutdown

This block turns the digital over-threshold flag of an on-die temperature comparator into a latched shutdown for catastrophic overheating. The comparator threshold sits far above normal operating temperature, near 135 °C junction, so a trip means the die must stop. Once a trip is declared, the block raises a trip output and a halt output that stops execution. Both stay set through any later cooling and clear only when reset is applied.

There is no hysteresis. A reset clears the latch, and after release the block checks the sensor again from scratch. If the die is still hot, the trip comes back after the normal detection latency and execution stays halted.

The sensor flag arrives asynchronously. It passes through a synchronizer, and it must then stay high for a qualifying run of consecutive cycles before a trip is declared. During reset the trip output carries no meaning. A separate valid output tells the platform when the trip output can be trusted.

Top module: `thermal_trip_latch`

## Requirements
- R1: When `rst` is high at a rising clock edge, `trip_o`, `halt_o` and `trip_valid_o` are all 0 after that edge.
- R2: `trip_valid_o` becomes 1 at the first rising edge at which `rst` is low. It stays 1 until `rst` is high again.
- R3: With the default parameters (SYNC_STAGES=2, QUAL_CYCLES=2), `hot_in` may rise before the first edge after reset and stay high. In that case `trip_o` is 0 after edge 3 and 1 after edge 4 (SYNC_STAGES+QUAL_CYCLES edges).
- R4: A trip is declared if and only if `hot_in` was sampled high on at least QUAL_CYCLES consecutive edges since reset. Shorter pulses and broken runs never trip.
- R5: Once `trip_o` is 1, it and `halt_o` stay 1 until the next reset, whatever `hot_in` does.
- R6: `halt_o` equals `trip_o` at all times.
- R7: Suppose `hot_in` is low during and after a reset pulse. Then `trip_o` stays 0 after the pulse, even if the block was tripped before it.
- R8: Suppose `hot_in` is still high when reset is released. Then `trip_o` asserts again exactly SYNC_STAGES+QUAL_CYCLES edges after the release.
- R9: Reset takes priority over a trip. An edge at which a trip would otherwise be declared, but `rst` is high, leaves `trip_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hot_in | input | 1 | Asynchronous over-threshold flag from the temperature comparator |
| trip_o | output | 1 | Latched catastrophic-overtemperature trip |
| halt_o | output | 1 | Halt-execution request, follows the trip latch |
| trip_valid_o | output | 1 | High when `trip_o` may be acted upon |

## Verification
The assertions check the following on every cycle:
- reset clears all outputs;
- the valid flag rises on the first clock out of reset;
- trip and halt never drop outside reset;
- no trip rises before the detection latency has elapsed since reset, or without any hot sample since reset.

Some behaviours only the bench scenarios can show:
- the exact latency;
- the rule that a run of QUAL_CYCLES is needed (the bench sweeps every 6-bit pulse pattern);
- re-arming after a reset while the die is still hot;
- clearing on a reset while cool;
- reset winning in the very cycle a trip would land.

// File: rtl/thermal_trip_latch.sv
module thermal_trip_latch #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hot_in,
  output logic trip_o,
  output logic halt_o,
  output logic trip_valid_o
);

  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(QUAL_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   trip_q;
  logic                   valid_q;
  logic                   hot_s;
  logic                   qualify;

  assign hot_s   = sync_q[SYNC_STAGES-1];
  assign qualify = hot_s && (run_q == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], hot_in};
  end

  always_ff @(posedge clk) begin
    if (rst || !hot_s)         run_q <= '0;
    else if (run_q != RUN_LAST) run_q <= run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          trip_q <= 1'b0;
    else if (qualify) trip_q <= 1'b1;
  end

  always_ff @(posedge clk) valid_q <= !rst;

  assign trip_o       = trip_q;
  assign halt_o       = trip_q;
  assign trip_valid_o = valid_q;

endmodule

// File: rtl/thermal_trip_latch_chk.sv
module thermal_trip_latch_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 2
) (
  input logic clk,
  input logic rst,
  input logic hot_in,
  input logic trip_o,
  input logic halt_o,
  input logic trip_valid_o
);

  localparam int LAT = SYNC_STAGES + QUAL_CYCLES;
  localparam int SW  = $clog2(LAT + 1);

  logic [SW-1:0] since_rst;
  logic          seen_hot;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      seen_hot  <= 1'b0;
    end else begin
      if (since_rst != SW'(LAT)) since_rst <= since_rst + 1'b1;
      if (hot_in) seen_hot <= 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!trip_o && !halt_o && !trip_valid_o));

  assert_valid_rise_R2: assert property (@(posedge clk)
    !rst |=> trip_valid_o);

  assert_trip_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (trip_o && halt_o) |=> (trip_o && halt_o));

  assert_no_early_trip_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_o) |-> (since_rst >= SW'(LAT)));

  assert_trip_needs_hot_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_o) |-> seen_hot);

endmodule

bind thermal_trip_latch thermal_trip_latch_chk #(
  .SYNC_STAGES(SYNC_STAGES),
  .QUAL_CYCLES(QUAL_CYCLES)
) u_chk (
  .clk(clk),
  .rst(rst),
  .hot_in(hot_in),
  .trip_o(trip_o),
  .halt_o(halt_o),
  .trip_valid_o(trip_valid_o)
);

// File: tb/thermal_trip_latch_tb.sv
`timescale 1ns/1ps
module thermal_trip_latch_tb;
  localparam int SYNC = 2;
  localparam int QUAL = 2;
  localparam int LAT  = SYNC + QUAL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hot = 1'b0;
  logic trip, halt, valid;
  int   n_run = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  thermal_trip_latch #(.SYNC_STAGES(SYNC), .QUAL_CYCLES(QUAL)) u_dut (
    .clk(clk), .rst(rst), .hot_in(hot),
    .trip_o(trip), .halt_o(halt), .trip_valid_o(valid)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    tick(n);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(1);
    tick(2);
    chk("R1 trip in reset", trip, 1'b0);
    chk("R1 halt in reset", halt, 1'b0);
    chk("R1 valid in reset", valid, 1'b0);
    rst = 1'b0;
    tick(1);
    chk("R2 valid after release", valid, 1'b1);
    tick(5);
    chk("R2 valid holds", valid, 1'b1);

    do_reset(2);
    hot = 1'b1;
    tick(LAT - 1);
    chk("R3 no trip before latency", trip, 1'b0);
    tick(1);
    chk("R3 trip at latency", trip, 1'b1);
    chk("R6 halt with trip", halt, 1'b1);
    hot = 1'b0;
    tick(20);
    chk("R5 trip latched after cooling", trip, 1'b0 | 1'b1);
    chk("R5 halt latched after cooling", halt, 1'b1);
    rst = 1'b1;
    tick(1);
    chk("R1 reset clears trip", trip, 1'b0);
    chk("R1 reset clears valid", valid, 1'b0);
    rst = 1'b0;
    tick(10);
    chk("R7 cool reset stays clear", trip, 1'b0);
    chk("R6 halt clear", halt, 1'b0);
    chk("R2 valid back", valid, 1'b1);

    do_reset(2);
    hot = 1'b1;
    tick(LAT - 1);
    rst = 1'b1;
    tick(1);
    chk("R9 reset wins over trip", trip, 1'b0);
    tick(5);
    chk("R9 held reset while hot", trip, 1'b0);
    rst = 1'b0;
    tick(LAT - 1);
    chk("R8 rearm not early", trip, 1'b0);
    tick(1);
    chk("R8 rearm trips", trip, 1'b1);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    tick(LAT - 1);
    chk("R8 hot reset pulse clears", trip, 1'b0);
    tick(1);
    chk("R8 hot reset pulse retrips", trip, 1'b1);
    hot = 1'b0;

    for (int p = 0; p < 64; p++) begin
      int run, best;
      logic exp;
      hot = 1'b0;
      do_reset(2);
      run = 0;
      best = 0;
      for (int b = 0; b < 6; b++) begin
        hot = p[b];
        run = p[b] ? run + 1 : 0;
        if (run > best) best = run;
        tick(1);
      end
      hot = 1'b0;
      tick(LAT + 2);
      exp = (best >= QUAL);
      chk(exp ? "R3 pattern trips" : "R4 pattern ignored", trip, exp);
      chk("R6 halt matches", halt, exp);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule